// File: doc/BRIEF.md
# Processor Status Word and Stack Pointer Selector

This block holds the status word of a 16-bit processor core together with its two stack pointers. One pointer serves interrupt handling and the other serves ordinary code. The ALU sends result strobes with a per-flag mask, and the block updates carry, zero, sign and overflow from them. Software can also load the whole 11-bit word in one write. The register-bank select and the maskable-interrupt enable are driven out to the rest of the core.

The block raises a single-step request after each completed instruction while the debug flag is set. It clears flags when an interrupt is entered, and three kinds of entry clear three different sets: a hardware acknowledge, a single-step acknowledge, and a software interrupt, where the set for a software interrupt depends on its number. Stack-pointer reads and writes always go to the pointer that the stack-select flag currently chooses. On the cycle of an interrupt entry, the old status word and the old pointer stay visible, so the caller can save the old state on the old stack. The cleared values appear one clock later.

Top module: `status_stack_unit`

## Requirements
- R1: After a synchronous active-low reset, all 11 flag bits are 0, both stack pointers are 0 and `step_req` is 0.
- R2: When `alu_upd` is 1, each set bit of `alu_mask` updates one flag on the next clock, and unmasked flags keep their values. The mask bits map as follows: mask bit 0 updates carry (flag bit 0) from `alu_carry`. Mask bit 1 updates zero (flag bit 2), which becomes 1 exactly when `alu_result` is all zeros. Mask bit 2 updates sign (flag bit 3) from the MSB of `alu_result`. Mask bit 3 updates overflow (flag bit 5) from `alu_ovf`. Flag bits 1, 4, 6, 7 and 8 to 10 never change through this path.
- R3: When `flag_wr_en` is 1, all 11 bits take `flag_wr_data` on the next clock. If an ALU update arrives in the same cycle, the direct write wins.
- R4: `bank_sel` always equals flag bit 4 and `int_en` always equals flag bit 6.
- R5: When `instr_done` is 1 while the debug flag (bit 1) is 1, `step_req` goes to 1 on the next clock and stays there until a step acknowledge. When `instr_done` is 1 while the debug flag is 0, `step_req` is not raised.
- R6: `step_ack` clears the debug flag, interrupt enable (bit 6), stack select (bit 7) and `step_req` on the next clock.
- R7: `hw_ack` clears interrupt enable and stack select on the next clock. All other bits are left as they were.
- R8: `sw_int` always clears interrupt enable. It also clears stack select when `sw_num` is below 32. At 32 and above, stack select is kept.
- R9: When an entry event and a direct flag write fall in the same cycle, the entry clearing wins for the bits it affects. The other bits take the written value.
- R10: `sp_rd_data` shows the interrupt pointer while stack select is 0 and the user pointer while it is 1. `sp_wr_en` writes only that active pointer, and the new value is visible on the next clock.
- R11: During the cycle of an entry event, `flags` and `sp_rd_data` still show the values from before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_mask | input | 4 | Flags to update: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow |
| alu_result | input | DATA_W | ALU result, the source of zero and sign |
| alu_carry | input | 1 | Carry, borrow or shift-out bit from the ALU |
| alu_ovf | input | 1 | Overflow indication from the ALU |
| flag_wr_en | input | 1 | Direct write of the whole status word |
| flag_wr_data | input | 11 | Value for the direct write |
| instr_done | input | 1 | An instruction completed this cycle |
| hw_ack | input | 1 | Hardware interrupt acknowledged |
| step_ack | input | 1 | Single-step interrupt acknowledged |
| sw_int | input | 1 | Software interrupt instruction executes |
| sw_num | input | VEC_W | Software interrupt number |
| sp_wr_en | input | 1 | Write to the active stack pointer |
| sp_wr_data | input | SP_W | Value for the stack pointer write |
| flags | output | 11 | Current status word |
| bank_sel | output | 1 | Register bank select |
| int_en | output | 1 | Maskable interrupt enable |
| sp_user_sel | output | 1 | 1 while the user pointer is active |
| sp_rd_data | output | SP_W | Value of the active stack pointer |
| step_req | output | 1 | Pending single-step interrupt request |

## Verification
Several pairs of functions can fall in the same cycle. A direct word write can meet an interrupt entry, a stack-pointer write can meet an entry that changes stack select, and a completed instruction can meet a step acknowledge. The bench provokes each pair in directed cycles: a write of all ones together with a hardware acknowledge, and a pointer write issued while an entry is pending. It also drives a long random stretch in which all of these strobes overlap freely. Every cycle is judged against a behavioural model that applies the stated priorities: entry clearing beats the direct write, the direct write beats the ALU, a pointer write lands on the pointer that was active before the edge, and acknowledge beats a new request.

// File: rtl/status_stack_pkg.sv
// Package: shared constants and types for the status word / stack unit.
// Assumes an 11-bit status word with fixed bit positions that other core
// logic decodes; the positions below are therefore behaviour, not layout.
package status_stack_pkg;

    localparam int FLAG_W    = 11;
    localparam int HI_FIELD_W = 3;

    // Status word bit positions (decoded elsewhere in the core).
    localparam int FB_CARRY = 0;
    localparam int FB_DEBUG = 1;
    localparam int FB_ZERO  = 2;
    localparam int FB_SIGN  = 3;
    localparam int FB_BANK  = 4;
    localparam int FB_OVF   = 5;
    localparam int FB_IEN   = 6;
    localparam int FB_USTK  = 7;
    localparam int FB_HI_LO = 8;

    // ALU update mask bit positions.
    localparam int AM_W     = 4;
    localparam int AM_CARRY = 0;
    localparam int AM_ZERO  = 1;
    localparam int AM_SIGN  = 2;
    localparam int AM_OVF   = 3;

    // Flags cleared by an interrupt entry event.
    typedef struct packed {
        logic dbg;
        logic ien;
        logic ustk;
    } entry_clr_t;

endpackage

// File: rtl/entry_clear_gen.sv
// Module: entry_clear_gen
// Turns the three interrupt-entry events into a set of flag clears.
// Assumes events may coincide; the resulting clear set is their union.
module entry_clear_gen
    import status_stack_pkg::*;
#(
    parameter int VEC_W         = 6,
    parameter int SWI_LOW_LIMIT = 32
) (
    input  logic             hw_ack,
    input  logic             step_ack,
    input  logic             sw_int,
    input  logic [VEC_W-1:0] sw_num,
    output entry_clr_t       clr
);

    localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(SWI_LOW_LIMIT);

    logic sw_low;

    // Classify the software interrupt number against the low range.
    always_comb begin
        sw_low = ({1'b0, sw_num} < LIMIT);
    end

    // Merge the clear sets of all entry events active this cycle.
    always_comb begin
        clr = '0;
        if (hw_ack) begin
            clr.ien  = 1'b1;
            clr.ustk = 1'b1;
        end
        if (step_ack) begin
            clr.dbg  = 1'b1;
            clr.ien  = 1'b1;
            clr.ustk = 1'b1;
        end
        if (sw_int) begin
            clr.ien = 1'b1;
            if (sw_low) begin
                clr.ustk = 1'b1;
            end
        end
    end

endmodule

// File: rtl/alu_flag_merge.sv
// Module: alu_flag_merge
// Combines the current status word with an ALU result strobe under a mask.
// Assumes only carry, zero, sign and overflow are reachable from the ALU.
module alu_flag_merge
    import status_stack_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [FLAG_W-1:0] flags_cur,
    input  logic              alu_upd,
    input  logic [AM_W-1:0]   alu_mask,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    output logic [FLAG_W-1:0] flags_alu
);

    logic [AM_W-1:0] src;

    // Derive the candidate value of each ALU-owned flag.
    always_comb begin
        src           = '0;
        src[AM_CARRY] = alu_carry;
        src[AM_ZERO]  = ~|alu_result;
        src[AM_SIGN]  = alu_result[DATA_W-1];
        src[AM_OVF]   = alu_ovf;
    end

    // Overwrite only the masked flags when the strobe is present.
    always_comb begin
        flags_alu = flags_cur;
        if (alu_upd) begin
            if (alu_mask[AM_CARRY]) flags_alu[FB_CARRY] = src[AM_CARRY];
            if (alu_mask[AM_ZERO])  flags_alu[FB_ZERO]  = src[AM_ZERO];
            if (alu_mask[AM_SIGN])  flags_alu[FB_SIGN]  = src[AM_SIGN];
            if (alu_mask[AM_OVF])   flags_alu[FB_OVF]   = src[AM_OVF];
        end
    end

endmodule

// File: rtl/flag_word_reg.sv
// Module: flag_word_reg
// Holds the status word. Priority: entry clears > direct write > ALU merge.
// Assumes the ALU-merged word is derived from this register's own output.
module flag_word_reg
    import status_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags_alu,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    input  entry_clr_t        clr,
    output logic [FLAG_W-1:0] flags_q
);

    logic [FLAG_W-1:0] flags_d;

    // Select the next word and apply entry clears last.
    always_comb begin
        flags_d = wr_en ? wr_data : flags_alu;
        if (clr.dbg)  flags_d[FB_DEBUG] = 1'b0;
        if (clr.ien)  flags_d[FB_IEN]   = 1'b0;
        if (clr.ustk) flags_d[FB_USTK]  = 1'b0;
    end

    // Store the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/step_request.sv
// Module: step_request
// Raises a single-step request after an instruction completes in debug mode.
// Assumes the acknowledge outranks a new request in the same cycle.
module step_request (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic dbg_flag,
    input  logic step_ack,
    output logic step_req
);

    // Set on completion with debug on, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                        step_req <= 1'b0;
        else if (step_ack)                 step_req <= 1'b0;
        else if (instr_done && dbg_flag)   step_req <= 1'b1;
    end

endmodule

// File: rtl/stack_bank.sv
// Module: stack_bank
// A bank of stack pointers; reads and writes go to the selected one.
// Assumes index 0 is the interrupt pointer and index 1 the user pointer.
module stack_bank #(
    parameter int SP_W   = 16,
    parameter int NUM_SP = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [((NUM_SP>1)?$clog2(NUM_SP):1)-1:0] sel,
    input  logic                                   wr_en,
    input  logic [SP_W-1:0]                        wr_data,
    output logic [SP_W-1:0]                        rd_data
);

    logic [SP_W-1:0] ptr_q [NUM_SP];

    for (genvar g = 0; g < NUM_SP; g++) begin : g_ptr
        // Hold one pointer; update it only while it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                            ptr_q[g] <= '0;
            else if (wr_en && (int'(sel) == g))    ptr_q[g] <= wr_data;
        end
    end

    // Present the selected pointer.
    always_comb begin
        rd_data = ptr_q[sel];
    end

endmodule

// File: rtl/status_stack_unit.sv
// Module: status_stack_unit (top)
// Status word, single-step request and interrupt/user stack pointers.
// Assumes all strobes are single-cycle and synchronous to clk; outputs
// reflect registered state only, so entry events show their effect a clock
// later and the old state is visible during the entry cycle.
module status_stack_unit
    import status_stack_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SP_W          = 16,
    parameter int VEC_W         = 6,
    parameter int SWI_LOW_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_upd,
    input  logic [AM_W-1:0]   alu_mask,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic              flag_wr_en,
    input  logic [FLAG_W-1:0] flag_wr_data,
    input  logic              instr_done,
    input  logic              hw_ack,
    input  logic              step_ack,
    input  logic              sw_int,
    input  logic [VEC_W-1:0]  sw_num,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    output logic [FLAG_W-1:0] flags,
    output logic              bank_sel,
    output logic              int_en,
    output logic              sp_user_sel,
    output logic [SP_W-1:0]   sp_rd_data,
    output logic              step_req
);

    entry_clr_t        clr;
    logic [FLAG_W-1:0] flags_alu;
    logic [FLAG_W-1:0] flags_q;

    entry_clear_gen #(
        .VEC_W         (VEC_W),
        .SWI_LOW_LIMIT (SWI_LOW_LIMIT)
    ) u_clr (
        .hw_ack   (hw_ack),
        .step_ack (step_ack),
        .sw_int   (sw_int),
        .sw_num   (sw_num),
        .clr      (clr)
    );

    alu_flag_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .flags_cur  (flags_q),
        .alu_upd    (alu_upd),
        .alu_mask   (alu_mask),
        .alu_result (alu_result),
        .alu_carry  (alu_carry),
        .alu_ovf    (alu_ovf),
        .flags_alu  (flags_alu)
    );

    flag_word_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_alu (flags_alu),
        .wr_en     (flag_wr_en),
        .wr_data   (flag_wr_data),
        .clr       (clr),
        .flags_q   (flags_q)
    );

    step_request u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .dbg_flag   (flags_q[FB_DEBUG]),
        .step_ack   (step_ack),
        .step_req   (step_req)
    );

    stack_bank #(
        .SP_W   (SP_W),
        .NUM_SP (2)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (flags_q[FB_USTK]),
        .wr_en   (sp_wr_en),
        .wr_data (sp_wr_data),
        .rd_data (sp_rd_data)
    );

    // Drive the status outputs from the stored word.
    always_comb begin
        flags       = flags_q;
        bank_sel    = flags_q[FB_BANK];
        int_en      = flags_q[FB_IEN];
        sp_user_sel = flags_q[FB_USTK];
    end

endmodule

// File: rtl/status_stack_chk.sv
// Module: status_stack_chk
// Temporal checks on the status unit's ports; attached by bind below.
module status_stack_chk
    import status_stack_pkg::*;
#(
    parameter int SP_W          = 16,
    parameter int VEC_W         = 6,
    parameter int SWI_LOW_LIMIT = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_upd,
    input logic              flag_wr_en,
    input logic              instr_done,
    input logic              hw_ack,
    input logic              step_ack,
    input logic              sw_int,
    input logic [VEC_W-1:0]  sw_num,
    input logic              sp_wr_en,
    input logic [FLAG_W-1:0] flags,
    input logic [SP_W-1:0]   sp_rd_data,
    input logic              step_req
);

    localparam logic [VEC_W:0] LIMIT = (VEC_W+1)'(SWI_LOW_LIMIT);

    logic sw_low;
    logic any_entry;
    always_comb begin
        sw_low    = ({1'b0, sw_num} < LIMIT);
        any_entry = hw_ack || step_ack || sw_int;
    end

    assert_alu_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && !flag_wr_en && !any_entry) |=>
        (flags[FLAG_W-1:FB_IEN] == $past(flags[FLAG_W-1:FB_IEN]) &&
         flags[FB_BANK] == $past(flags[FB_BANK]) &&
         flags[FB_DEBUG] == $past(flags[FB_DEBUG])));

    assert_step_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && flags[FB_DEBUG] && !step_ack) |=> step_req);

    assert_step_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_ack |=> (!step_req && !flags[FB_DEBUG] && !flags[FB_IEN] && !flags[FB_USTK]));

    assert_hw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ack |=> (!flags[FB_IEN] && !flags[FB_USTK]));

    assert_sw_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_int && sw_low) |=> (!flags[FB_IEN] && !flags[FB_USTK]));

    assert_sw_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_int && !sw_low && !hw_ack && !step_ack && !flag_wr_en) |=>
        (!flags[FB_IEN] && flags[FB_USTK] == $past(flags[FB_USTK])));

    assert_sp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_wr_en && !flag_wr_en && !any_entry) |=> $stable(sp_rd_data));

endmodule

bind status_stack_unit status_stack_chk #(
    .SP_W          (SP_W),
    .VEC_W         (VEC_W),
    .SWI_LOW_LIMIT (SWI_LOW_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_upd    (alu_upd),
    .flag_wr_en (flag_wr_en),
    .instr_done (instr_done),
    .hw_ack     (hw_ack),
    .step_ack   (step_ack),
    .sw_int     (sw_int),
    .sw_num     (sw_num),
    .sp_wr_en   (sp_wr_en),
    .flags      (flags),
    .sp_rd_data (sp_rd_data),
    .step_req   (step_req)
);

// File: tb/status_stack_unit_tb.sv
// Bench: behavioural per-cycle model compared on every falling edge, plus
// directed checks for each requirement.
module status_stack_unit_tb;

    localparam int DW = 16;
    localparam int SW = 16;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alu_upd = 1'b0;
    logic [3:0]    alu_mask = '0;
    logic [DW-1:0] alu_result = '0;
    logic          alu_carry = 1'b0;
    logic          alu_ovf = 1'b0;
    logic          flag_wr_en = 1'b0;
    logic [10:0]   flag_wr_data = '0;
    logic          instr_done = 1'b0;
    logic          hw_ack = 1'b0;
    logic          step_ack = 1'b0;
    logic          sw_int = 1'b0;
    logic [VW-1:0] sw_num = '0;
    logic          sp_wr_en = 1'b0;
    logic [SW-1:0] sp_wr_data = '0;
    logic [10:0]   flags;
    logic          bank_sel;
    logic          int_en;
    logic          sp_user_sel;
    logic [SW-1:0] sp_rd_data;
    logic          step_req;

    status_stack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_mask(alu_mask),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .instr_done(instr_done), .hw_ack(hw_ack), .step_ack(step_ack),
        .sw_int(sw_int), .sw_num(sw_num), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .flags(flags), .bank_sel(bank_sel),
        .int_en(int_en), .sp_user_sel(sp_user_sel), .sp_rd_data(sp_rd_data),
        .step_req(step_req)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string phase = "R1";

    // Reference model state
    int m_flags = 0;
    int m_isp = 0;
    int m_usp = 0;
    int m_req = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Model: next state from the requirements.
    always @(posedge clk) begin
        int nf;
        int u;
        if (!rst_n) begin
            m_flags = 0; m_isp = 0; m_usp = 0; m_req = 0;
        end else begin
            u  = (m_flags >> 7) & 1;
            nf = m_flags;
            if (alu_upd) begin
                if (alu_mask[0]) nf = alu_carry ? (nf | 'h1) : (nf & ~'h1);
                if (alu_mask[1]) nf = (alu_result == 0) ? (nf | 'h4) : (nf & ~'h4);
                if (alu_mask[2]) nf = alu_result[DW-1] ? (nf | 'h8) : (nf & ~'h8);
                if (alu_mask[3]) nf = alu_ovf ? (nf | 'h20) : (nf & ~'h20);
            end
            if (flag_wr_en) nf = int'(flag_wr_data);
            if (hw_ack)   nf = nf & ~'hC0;
            if (step_ack) nf = nf & ~'hC2;
            if (sw_int) begin
                nf = nf & ~'h40;
                if (sw_num < 32) nf = nf & ~'h80;
            end
            if (step_ack) m_req = 0;
            else if (instr_done && ((m_flags >> 1) & 1) == 1) m_req = 1;
            if (sp_wr_en) begin
                if (u == 1) m_usp = int'(sp_wr_data);
                else        m_isp = int'(sp_wr_data);
            end
            m_flags = nf & 'h7FF;
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "flags", int'(flags), m_flags);
            check(phase, "sp_rd_data", int'(sp_rd_data), (((m_flags >> 7) & 1) == 1) ? m_usp : m_isp);
            check(phase, "step_req", int'(step_req), m_req);
            check("R4", "bank_sel", int'(bank_sel), (m_flags >> 4) & 1);
            check("R4", "int_en", int'(int_en), (m_flags >> 6) & 1);
            check("R10", "sp_user_sel", int'(sp_user_sel), (m_flags >> 7) & 1);
        end
    end

    task automatic idle();
        alu_upd = 0; alu_mask = '0; alu_result = '0; alu_carry = 0; alu_ovf = 0;
        flag_wr_en = 0; flag_wr_data = '0; instr_done = 0; hw_ack = 0;
        step_ack = 0; sw_int = 0; sw_num = '0; sp_wr_en = 0; sp_wr_data = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic wr_flags(input logic [10:0] v);
        flag_wr_en = 1; flag_wr_data = v; tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R1";
        check("R1", "reset flags", int'(flags), 0);
        check("R1", "reset sp", int'(sp_rd_data), 0);
        check("R1", "reset step_req", int'(step_req), 0);

        phase = "R2";
        alu_upd = 1; alu_mask = 4'b1111; alu_result = 16'h0000; alu_carry = 1; tick();
        check("R2", "zero+carry", int'(flags), 'h005);
        alu_upd = 1; alu_mask = 4'b0100; alu_result = 16'h8000; tick();
        check("R2", "sign only", int'(flags), 'h00D);

        phase = "R3";
        wr_flags(11'h5D2);
        check("R3", "direct write", int'(flags), 'h5D2);
        check("R4", "bank_sel", int'(bank_sel), 1);
        check("R4", "int_en", int'(int_en), 1);

        phase = "R10";
        sp_wr_en = 1; sp_wr_data = 16'h1234; tick();
        check("R10", "user sp write", int'(sp_rd_data), 'h1234);

        phase = "R5";
        instr_done = 1; tick();
        check("R5", "step_req set", int'(step_req), 1);
        tick();
        check("R5", "step_req held", int'(step_req), 1);

        phase = "R7";
        hw_ack = 1;
        #1;
        check("R11", "flags during ack", int'(flags), 'h5D2);
        check("R11", "sp during ack", int'(sp_rd_data), 'h1234);
        tick();
        check("R7", "hw_ack clears", int'(flags), 'h512);
        check("R10", "isp active", int'(sp_rd_data), 0);
        check("R7", "step_req kept", int'(step_req), 1);

        phase = "R10";
        sp_wr_en = 1; sp_wr_data = 16'hBEEF; tick();
        check("R10", "isp write", int'(sp_rd_data), 'hBEEF);
        wr_flags(11'h5D2);
        check("R10", "usp untouched", int'(sp_rd_data), 'h1234);

        phase = "R6";
        step_ack = 1; tick();
        check("R6", "step_ack flags", int'(flags), 'h510);
        check("R6", "step_ack req", int'(step_req), 0);

        phase = "R8";
        wr_flags(11'h0C0);
        sw_int = 1; sw_num = 6'd32; tick();
        check("R8", "swi 32", int'(flags), 'h080);
        wr_flags(11'h0C0);
        sw_int = 1; sw_num = 6'd31; tick();
        check("R8", "swi 31", int'(flags), 'h000);

        phase = "R9";
        flag_wr_en = 1; flag_wr_data = 11'h7FF; hw_ack = 1; tick();
        check("R9", "write vs ack", int'(flags), 'h73F);

        phase = "R2";
        wr_flags(11'h0D2);
        alu_upd = 1; alu_mask = 4'b1111; alu_result = 16'h0001; alu_ovf = 1; tick();
        check("R2", "protected bits", int'(flags), 'h0F2);

        phase = "R3";
        flag_wr_en = 1; flag_wr_data = 11'h001;
        alu_upd = 1; alu_mask = 4'b1111; alu_result = 16'h0000; tick();
        check("R3", "write beats alu", int'(flags), 'h001);

        phase = "R5";
        instr_done = 1; tick();
        check("R5", "no req without debug", int'(step_req), 0);

        phase = "random R2,R3,R5,R6,R7,R8,R9,R10,R11";
        for (int i = 0; i < 4000; i++) begin
            alu_upd      = ($urandom_range(0, 2) == 0);
            alu_mask     = 4'($urandom_range(0, 15));
            alu_result   = ($urandom_range(0, 3) == 0) ? '0 : DW'($urandom);
            alu_carry    = 1'($urandom_range(0, 1));
            alu_ovf      = 1'($urandom_range(0, 1));
            flag_wr_en   = ($urandom_range(0, 4) == 0);
            flag_wr_data = 11'($urandom);
            instr_done   = ($urandom_range(0, 1) == 0);
            hw_ack       = ($urandom_range(0, 7) == 0);
            step_ack     = ($urandom_range(0, 7) == 0);
            sw_int       = ($urandom_range(0, 7) == 0);
            sw_num       = VW'($urandom_range(28, 36));
            sp_wr_en     = ($urandom_range(0, 2) == 0);
            sp_wr_data   = SW'($urandom);
            @(negedge clk);
        end
        idle();
        tick();
        finish_run();
    end

endmodule